// File: doc/BRIEF.md
# Paired Data/Direction Boundary-Scan Register

This block is a boundary-scan register for a bank of controlled pins. Each pin owns two serial cells: a data cell and a direction cell. The direction cell sits right after its data cell in the scan path, so the chain is twice as long as the pin count. A full reload therefore takes two shifts per pin. Behind the serial cells sits a bank of update latches. The latches hold the value that test modes apply to the pads and to the core, and they stay still while new bits move through the chain.

A TAP controller drives the block through three plain strobes (capture, shift, update), each sampled on a rising clock edge. It also supplies a mode code decoded from the current instruction. The block sits between the core and the pads:

- **Functional and sample/preload:** core signals pass straight through, and the chain can observe the pins and preload the latches.
- **External test:** the latches drive the pads.
- **High-impedance:** every pad is released.
- **Internal test:** the latched data feeds the core inputs, and the chain captures the core's outputs.

There is no streaming data path, so the strobes and the mode have no valid/ready handshake. A strobe acts on every edge where it is high.

Top module: `bscan_pair_chain`

## Requirements
- R1: The chain holds 2*NUM_PINS cells. Cell 2p is the data cell of pin p and cell 2p+1 is its direction cell. Cell 0 takes `scan_in` and `scan_out` shows the last cell. The first bit of a full load therefore lands in the direction cell of pin NUM_PINS-1.
- R2: The update latches copy the chain only on an edge with `update_en` high and hold otherwise. Pad outputs stay static while a shift is in progress.
- R3: In external test (`mode` = 3'd1), `pin_out` equals the latched data. `pin_oe` equals the latched direction, where 1 drives the pin and 0 leaves it as an input.
- R4: On an edge with `capture_en` high, each data cell loads its pin value and each direction cell loads its latched direction bit. Capture takes priority over a shift in the same cycle.
- R5: In sample/preload (`mode` = 3'd2), pads carry the core's values and `core_in` carries `pin_in`. Latches loaded in this mode appear on the pads as soon as the mode becomes external test.
- R6: In high-impedance (`mode` = 3'd3), every `pin_oe` bit is 0 and `pin_out` is 0, whatever the latches or the core hold.
- R7: In internal test (`mode` = 3'd4), `core_in` equals the latched data and the pads are undriven. A capture loads `core_out` into the data cells.
- R8: In functional mode (`mode` = 3'd0) and for the unused codes 3'd5 to 3'd7, pads carry `core_out`/`core_oe` and `core_in` carries `pin_in`.
- R9: After reset, every chain cell and every latch is 0, so no pin is driven in external test.
- R10: With the default 101 pins, a 16-bit word loaded with bit i at pin 85+i appears on `pin_out[100:85]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Test mode code (see R3 to R8) |
| capture_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| update_en | input | 1 | Update strobe |
| scan_in | input | 1 | Serial input into cell 0 |
| scan_out | output | 1 | Serial output from the last cell |
| core_out | input | NUM_PINS | Core-driven pin values |
| core_oe | input | NUM_PINS | Core-driven output enables |
| core_in | output | NUM_PINS | Pin values delivered to the core |
| pin_in | input | NUM_PINS | Values sensed at the pads |
| pin_out | output | NUM_PINS | Values sent to the pads |
| pin_oe | output | NUM_PINS | Pad output enables |

## Verification
The bench targets the chain order first. A design that swapped the data and direction cells, or reversed the pin order, would put loaded words on the wrong pads and return captured vectors scrambled.

It also checks that the pads stay static during long shifts. A design that let latches follow the chain would make the outputs ripple.

A capture strobe is driven together with a shift strobe. A design with the wrong priority would return a shifted chain instead of pad values.

High-impedance is run with all latches and all core enables set to 1. Any leak would then show up as a driven pin.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  typedef enum logic [2:0] {
    BS_FUNC   = 3'd0,
    BS_EXTEST = 3'd1,
    BS_SAMPLE = 3'd2,
    BS_HIGHZ  = 3'd3,
    BS_INTEST = 3'd4
  } bs_mode_e;
endpackage

// File: rtl/bscan_cell_pair.sv
// One pin's slice: a data cell followed by its direction cell, plus two update latches.
module bscan_cell_pair (
  input  logic clk,
  input  logic rst_n,
  input  logic capture_en,
  input  logic shift_en,
  input  logic update_en,
  input  logic ser_in,
  input  logic cap_val,
  output logic ser_out,
  output logic cell_ctrl,
  output logic lat_data,
  output logic lat_ctrl
);
  logic data_q;
  logic ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= 1'b0;
      ctrl_q   <= 1'b0;
      lat_data <= 1'b0;
      lat_ctrl <= 1'b0;
    end else begin
      if (capture_en) begin
        data_q <= cap_val;
        ctrl_q <= lat_ctrl;
      end else if (shift_en) begin
        data_q <= ser_in;
        ctrl_q <= data_q;
      end
      if (update_en) begin
        lat_data <= data_q;
        lat_ctrl <= ctrl_q;
      end
    end
  end

  assign ser_out   = ctrl_q;
  assign cell_ctrl = ctrl_q;
endmodule

// File: rtl/bscan_pin_mux.sv
// Selects pad and core-side values according to the test mode.
module bscan_pin_mux #(
  parameter int WIDTH = 8
) (
  input  logic [2:0]       mode,
  input  logic [WIDTH-1:0] lat_data,
  input  logic [WIDTH-1:0] lat_ctrl,
  input  logic [WIDTH-1:0] core_out,
  input  logic [WIDTH-1:0] core_oe,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] core_in,
  output logic [WIDTH-1:0] cap_val
);
  import bscan_pkg::*;

  always_comb begin
    pin_out = core_out;
    pin_oe  = core_oe;
    core_in = pin_in;
    cap_val = pin_in;
    case (mode)
      BS_EXTEST: begin
        pin_out = lat_data;
        pin_oe  = lat_ctrl;
      end
      BS_HIGHZ: begin
        pin_out = '0;
        pin_oe  = '0;
      end
      BS_INTEST: begin
        pin_out = '0;
        pin_oe  = '0;
        core_in = lat_data;
        cap_val = core_out;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bscan_pair_chain.sv
module bscan_pair_chain #(
  parameter int NUM_PINS = 101
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          mode,
  input  logic                capture_en,
  input  logic                shift_en,
  input  logic                update_en,
  input  logic                scan_in,
  output logic                scan_out,
  input  logic [NUM_PINS-1:0] core_out,
  input  logic [NUM_PINS-1:0] core_oe,
  output logic [NUM_PINS-1:0] core_in,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);
  localparam int CHAIN_LEN = 2 * NUM_PINS;

  logic [NUM_PINS:0]   link;
  logic [NUM_PINS-1:0] lat_data_v;
  logic [NUM_PINS-1:0] lat_ctrl_v;
  logic [NUM_PINS-1:0] cell_ctrl_v;
  logic [NUM_PINS-1:0] cap_val_v;

  assign link[0] = scan_in;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_slice
    bscan_cell_pair u_pair (
      .clk        (clk),
      .rst_n      (rst_n),
      .capture_en (capture_en),
      .shift_en   (shift_en),
      .update_en  (update_en),
      .ser_in     (link[p]),
      .cap_val    (cap_val_v[p]),
      .ser_out    (link[p+1]),
      .cell_ctrl  (cell_ctrl_v[p]),
      .lat_data   (lat_data_v[p]),
      .lat_ctrl   (lat_ctrl_v[p])
    );
  end

  assign scan_out = link[NUM_PINS];

  bscan_pin_mux #(.WIDTH(NUM_PINS)) u_mux (
    .mode     (mode),
    .lat_data (lat_data_v),
    .lat_ctrl (lat_ctrl_v),
    .core_out (core_out),
    .core_oe  (core_oe),
    .pin_in   (pin_in),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .core_in  (core_in),
    .cap_val  (cap_val_v)
  );

  logic unused_len;
  assign unused_len = (CHAIN_LEN == 0);
endmodule

// File: rtl/bscan_pair_chain_chk.sv
module bscan_pair_chain_chk #(
  parameter int NUM_PINS = 101
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2:0]          mode,
  input logic                capture_en,
  input logic                update_en,
  input logic [NUM_PINS-1:0] core_out,
  input logic [NUM_PINS-1:0] core_oe,
  input logic [NUM_PINS-1:0] core_in,
  input logic [NUM_PINS-1:0] pin_in,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NUM_PINS-1:0] lat_data_v,
  input logic [NUM_PINS-1:0] lat_ctrl_v,
  input logic [NUM_PINS-1:0] cell_ctrl_v
);
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !update_en |=> ($stable(lat_data_v) && $stable(lat_ctrl_v))); // R2
  AST_EXTEST_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1) |-> (pin_oe == lat_ctrl_v && pin_out == lat_data_v)); // R3
  AST_CAPTURE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en |=> (cell_ctrl_v == $past(lat_ctrl_v))); // R4
  AST_SAMPLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2) |-> (pin_out == core_out && pin_oe == core_oe && core_in == pin_in)); // R5
  AST_HIGHZ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3) |-> (pin_oe == '0 && pin_out == '0)); // R6
  AST_INTEST_FEED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4) |-> (core_in == lat_data_v && pin_oe == '0)); // R7
endmodule

bind bscan_pair_chain bscan_pair_chain_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode        (mode),
  .capture_en  (capture_en),
  .update_en   (update_en),
  .core_out    (core_out),
  .core_oe     (core_oe),
  .core_in     (core_in),
  .pin_in      (pin_in),
  .pin_out     (pin_out),
  .pin_oe      (pin_oe),
  .lat_data_v  (lat_data_v),
  .lat_ctrl_v  (lat_ctrl_v),
  .cell_ctrl_v (cell_ctrl_v)
);

// File: tb/sim_bscan_pair_chain.sv
module sim_bscan_pair_chain;
  localparam int N = 101;
  localparam int L = 2 * N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode = 3'd0;
  logic capture_en = 1'b0, shift_en = 1'b0, update_en = 1'b0, scan_in = 1'b0;
  logic scan_out;
  logic [N-1:0] core_out = '0, core_oe = '0, pin_in = '0;
  logic [N-1:0] core_in, pin_out, pin_oe;

  int tests = 0;
  int fails = 0;
  int ripple = 0;
  logic [N-1:0] cur_ctrl = '0;
  logic [N-1:0] rd_data, rd_ctrl;

  always #2.5 clk = ~clk;

  bscan_pair_chain #(.NUM_PINS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .capture_en(capture_en),
    .shift_en(shift_en), .update_en(update_en), .scan_in(scan_in),
    .scan_out(scan_out), .core_out(core_out), .core_oe(core_oe),
    .core_in(core_in), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] rnd();
    logic [N-1:0] r;
    for (int p = 0; p < N; p++) r[p] = 1'($urandom % 2);
    return r;
  endfunction

  task automatic cycle(logic cap, logic sh, logic upd, logic sin);
    capture_en = cap; shift_en = sh; update_en = upd; scan_in = sin;
    @(posedge clk);
    @(negedge clk);
    capture_en = 0; shift_en = 0; update_en = 0; scan_in = 0;
  endtask

  // Shift a full image (last pin's direction first), then update. R1, R2
  task automatic load(logic [N-1:0] d, logic [N-1:0] c);
    logic [N-1:0] po, oe;
    po = pin_out; oe = pin_oe;
    for (int k = L - 1; k >= 0; k--) begin
      cycle(1'b0, 1'b1, 1'b0, (k % 2 == 1) ? c[k/2] : d[k/2]);
      if (pin_out !== po || pin_oe !== oe) ripple++;
    end
    cycle(1'b0, 1'b0, 1'b1, 1'b0);
    cur_ctrl = c;
  endtask

  // Capture (optionally with shift high too) and read the whole chain back.
  task automatic readback(logic with_shift);
    cycle(1'b1, with_shift, 1'b0, 1'b1);
    for (int i = 0; i < L; i++) begin
      int k;
      k = L - 1 - i;
      if (k % 2 == 1) rd_ctrl[k/2] = scan_out; else rd_data[k/2] = scan_out;
      cycle(1'b0, 1'b1, 1'b0, 1'b0);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [N-1:0] d, c, w;
    void'($urandom(32'h5eed1234));
    mode = 3'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset pin_oe", pin_oe, '0);
    chk("R9 reset pin_out", pin_out, '0);
    chk("R9 reset scan_out", {{(N-1){1'b0}}, scan_out}, '0);

    // R3 / R1 / R2 random loads in external test
    for (int t = 0; t < 4; t++) begin
      d = rnd(); c = rnd();
      ripple = 0;
      load(d, c);
      chk("R3 pin_out", pin_out, d);
      chk("R3 pin_oe", pin_oe, c);
      chk("R2 static during shift", N'(ripple), '0);
    end

    // R10 data-bus word
    d = '0; c = '0;
    w = '0; w[15:0] = 16'hA5C3;
    for (int i = 0; i < 16; i++) begin d[85+i] = w[i]; c[85+i] = 1'b1; end
    load(d, c);
    chk("R10 bus word", N'(pin_out[100:85]), N'(16'hA5C3));
    chk("R10 bus enables", N'(pin_oe[100:85]), N'(16'hFFFF));

    // R4 / R1 capture and read back
    for (int t = 0; t < 3; t++) begin
      pin_in = rnd();
      readback(1'b0);
      chk("R4 capture data cells", rd_data, pin_in);
      chk("R4 capture direction cells", rd_ctrl, cur_ctrl);
    end
    pin_in = rnd();
    readback(1'b1);
    chk("R4 capture beats shift", rd_data, pin_in);

    // R5 sample/preload
    mode = 3'd2;
    core_out = rnd(); core_oe = rnd(); pin_in = rnd();
    @(negedge clk);
    chk("R5 pins follow core", pin_out, core_out);
    chk("R5 oe follow core", pin_oe, core_oe);
    chk("R5 core_in follows pad", core_in, pin_in);
    d = rnd(); c = rnd();
    load(d, c);
    chk("R5 no disturbance during preload", pin_out, core_out);
    mode = 3'd1;
    @(negedge clk);
    chk("R5 preload on pads", pin_out, d);
    chk("R5 preload enables", pin_oe, c);

    // R6 high-impedance with everything trying to drive
    load('1, '1);
    mode = 3'd3; core_oe = '1; core_out = '1;
    @(negedge clk);
    chk("R6 oe released", pin_oe, '0);
    chk("R6 out low", pin_out, '0);

    // R7 internal test
    mode = 3'd4;
    d = rnd(); c = rnd();
    load(d, c);
    chk("R7 core_in from latch", core_in, d);
    chk("R7 pads undriven", pin_oe, '0);
    core_out = rnd();
    readback(1'b0);
    chk("R7 capture core_out", rd_data, core_out);

    // R8 functional and unused codes
    mode = 3'd0; core_out = rnd(); core_oe = rnd(); pin_in = rnd();
    @(negedge clk);
    chk("R8 func pin_out", pin_out, core_out);
    chk("R8 func core_in", core_in, pin_in);
    mode = 3'd6;
    @(negedge clk);
    chk("R8 unused code oe", pin_oe, core_oe);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule